// File: doc/BRIEF.md
# UART Channel Interrupt and Line Status Unit

This unit produces the line status byte, the interrupt identification code and the interrupt request line for one channel of a 16550-class UART whose transmit and receive queues each hold up to 128 characters. Its inputs are the occupancy counts of both queues, the transmitter idle flag, a strobe for each character that enters the receive queue together with that character's error flags, the interrupt enable nibble, the queue enable bit and a receive threshold selector. Host access strobes tell it when the status byte or the identification register is read and when a character is written for transmission.

The unit has no data path, so it has no valid/ready handshake. Every input strobe marks one event in one clock cycle and is never held off. Back-pressure cannot arise because the unit never refuses an event. All outputs are combinational functions of the current inputs and a small amount of sticky state. That state updates on the clock edge that samples the strobes.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is applied and afterwards, with an empty transmit queue, an idle transmitter and no received data, `lsr` reads 8'h60, `isr_id` reads 4'b0001 and `irq` is 0.
- R2: With queues enabled and `ier[0]` set, the receive source is active whenever `rx_count` is at or above the threshold chosen by `trig_sel` (0: 1, 1: DEPTH/4, 2: DEPTH/2, 3: DEPTH). It goes inactive as soon as the count is below that threshold. Its identification code is 4'b0100.
- R3: `lsr[0]` is 1 whenever the receive queue holds at least one character and 0 when it is empty.
- R4: With `ier[1]` set, the transmit source is active when `tx_count` is 0 and the source is armed. Its identification code is 4'b0010. The source is armed after reset.
- R5: A strobe on `isr_rd` disarms the transmit source only if 4'b0010 is being reported in that cycle. A `thr_wr` strobe re-arms it, so the next time the queue is empty the interrupt is raised again.
- R6: `lsr[5]` is 1 when `tx_count` is 0. `lsr[6]` is 1 when `tx_count` is 0 and `tsr_idle` is 1.
- R7: The error flags `rx_err[3:0]` (overrun, parity, framing, break) are captured on `rx_push` into `lsr[1]`..`lsr[4]`. They stay set until a `lsr_rd` strobe, which clears them.
- R8: In queue mode, `lsr[7]` sets when a character with any error flag enters the queue. A `lsr_rd` strobe reloads it from `rx_err_present`, so it clears only when no erroneous character remains. In non-queue mode it reads 0.
- R9: With queues enabled and `ier[3:0]` all zero (polled mode), `irq` stays 0 while all `lsr` bits keep updating.
- R10: With `fifo_en` at 0, the receive source follows whether any character is held, regardless of `trig_sel`. The transmit source follows `lsr[5]`.
- R11: Priority runs from line-status error (4'b0110, needs `ier[2]`), to receive, to transmit. Only the highest active source is reported. `isr_id` is 4'b0001 with `irq` at 0 when nothing is pending, and `irq` is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue mode enable |
| ier | input | 4 | Interrupt enables: [0] receive, [1] transmit, [2] line status, [3] reserved |
| trig_sel | input | 2 | Receive threshold selector |
| rx_count | input | CW | Receive queue occupancy |
| rx_push | input | 1 | A character enters the receive queue this cycle |
| rx_err | input | 4 | Error flags of the pushed character |
| rx_err_present | input | 1 | Some queued character still carries an error |
| tx_count | input | CW | Transmit queue occupancy |
| tsr_idle | input | 1 | Transmit shifter is empty |
| isr_rd | input | 1 | Host read of the identification register |
| lsr_rd | input | 1 | Host read of the status byte |
| thr_wr | input | 1 | Host write of a transmit character |
| lsr | output | 8 | Line status byte |
| isr_id | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several rules on every cycle: the request line agrees with the reported code, polled mode stays silent, `lsr[6]` never appears without `lsr[5]`, error flags persist until a status read, and an identification read that reports the transmit source drops it. Only the bench scenarios can show the threshold boundaries for each selector and the exact rule for reloading `lsr[7]`. They also show re-arming after a transmit write, that an identification read leaves the transmit source armed while receive is reported, and the non-queue mode behaviour.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_TX   = 4'b0010,
    ID_RX   = 4'b0100,
    ID_LS   = 4'b0110
  } irq_id_e;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_lsr_errs.sv
module uart_lsr_errs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       rx_push,
  input  logic [3:0] rx_err,
  input  logic       rx_err_present,
  input  logic       lsr_rd,
  output logic [3:0] err_bits,
  output logic       fifo_err
);
  logic       err_in;
  logic [3:0] err_q;
  logic       ferr_q;

  assign err_in = rx_push && (rx_err != 4'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (lsr_rd) begin
      err_q <= rx_push ? rx_err : 4'b0;
    end else if (rx_push) begin
      err_q <= err_q | rx_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= 1'b0;
    end else if (err_in && fifo_en) begin
      ferr_q <= 1'b1;
    end else if (lsr_rd) begin
      ferr_q <= rx_err_present;
    end
  end

  assign err_bits = err_q;
  assign fifo_err = fifo_en & ferr_q;
endmodule

// File: rtl/uart_thre_arm.sv
module uart_thre_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic isr_rd,
  input  logic tx_reported,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (thr_wr) begin
      armed <= 1'b1;
    end else if (isr_rd && tx_reported) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic    ls_src,
  input  logic    rx_src,
  input  logic    tx_src,
  input  logic    polled,
  output irq_id_e id,
  output logic    irq
);
  always_comb begin
    if (ls_src)      id = ID_LS;
    else if (rx_src) id = ID_RX;
    else if (tx_src) id = ID_TX;
    else             id = ID_NONE;
  end

  assign irq = (id != ID_NONE) && !polled;
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [3:0]    ier,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic [3:0]    rx_err,
  input  logic          rx_err_present,
  input  logic [CW-1:0] tx_count,
  input  logic          tsr_idle,
  input  logic          isr_rd,
  input  logic          lsr_rd,
  input  logic          thr_wr,
  output logic [7:0]    lsr,
  output logic [3:0]    isr_id,
  output logic          irq
);
  logic [CW-1:0] trig;
  logic          rx_any, tx_empty, rx_src, tx_src, ls_src, polled, armed, fifo_err;
  logic [3:0]    err_bits;
  irq_id_e       id;

  assign trig     = CW'(trig_level(trig_sel, DEPTH));
  assign rx_any   = (rx_count != '0);
  assign tx_empty = (tx_count == '0);
  assign polled   = fifo_en && (ier == 4'b0);

  assign rx_src = ier[0] && (fifo_en ? (rx_count >= trig) : rx_any);
  assign tx_src = ier[1] && tx_empty && armed;
  assign ls_src = ier[2] && (err_bits != 4'b0);

  uart_lsr_errs u_errs (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_push(rx_push),
    .rx_err(rx_err), .rx_err_present(rx_err_present), .lsr_rd(lsr_rd),
    .err_bits(err_bits), .fifo_err(fifo_err)
  );

  uart_thre_arm u_arm (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .isr_rd(isr_rd),
    .tx_reported(id == ID_TX), .armed(armed)
  );

  uart_irq_encode u_enc (
    .ls_src(ls_src), .rx_src(rx_src), .tx_src(tx_src), .polled(polled),
    .id(id), .irq(irq)
  );

  assign isr_id = id;
  assign lsr    = {fifo_err, tx_empty && tsr_idle, tx_empty, err_bits, rx_any};
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic [3:0] ier,
  input logic       isr_rd,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic [7:0] lsr,
  input logic [3:0] isr_id,
  input logic       irq
);
  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && ier == 4'b0)) |-> (irq == (isr_id != 4'b0001))); // R11
  AST_POLLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && ier == 4'b0) |-> !irq); // R9
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_rd && lsr[2]) |=> lsr[2]); // R7
  AST_TX_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !thr_wr && isr_id == 4'b0010) |=> (isr_id != 4'b0010)); // R5
  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_id == 4'b0001 || isr_id == 4'b0010 || isr_id == 4'b0100 || isr_id == 4'b0110)); // R11
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .isr_rd(isr_rd),
  .lsr_rd(lsr_rd), .thr_wr(thr_wr), .lsr(lsr), .isr_id(isr_id), .irq(irq)
);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b1;
  logic [3:0]    ier = 4'b0;
  logic [1:0]    trig_sel = 2'd1;
  logic [CW-1:0] rx_count = '0;
  logic          rx_push = 1'b0;
  logic [3:0]    rx_err = 4'b0;
  logic          rx_err_present = 1'b0;
  logic [CW-1:0] tx_count = '0;
  logic          tsr_idle = 1'b1;
  logic          isr_rd = 1'b0;
  logic          lsr_rd = 1'b0;
  logic          thr_wr = 1'b0;
  logic [7:0]    lsr;
  logic [3:0]    isr_id;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_status dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .trig_sel(trig_sel),
    .rx_count(rx_count), .rx_push(rx_push), .rx_err(rx_err),
    .rx_err_present(rx_err_present), .tx_count(tx_count), .tsr_idle(tsr_idle),
    .isr_rd(isr_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr),
    .lsr(lsr), .isr_id(isr_id), .irq(irq)
  );

  // Monitor: compares one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [12:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({lsr, isr_id, irq} !== e) begin
        fails++;
        $display("FAIL %s: lsr=%h id=%b irq=%b expected lsr=%h id=%b irq=%b",
                 t, lsr, isr_id, irq, e[12:5], e[4:1], e[0]);
      end
    end
  end

  task automatic step(input logic fe, input logic [3:0] ie, input logic [1:0] ts,
                      input int rxc, input logic psh, input logic [3:0] er, input logic pres,
                      input int txc, input logic idle, input logic ird, input logic lrd,
                      input logic twr, input logic [7:0] e_lsr, input logic [3:0] e_id,
                      input logic e_irq, input string tag);
    @(posedge clk);
    #1;
    fifo_en = fe; ier = ie; trig_sel = ts; rx_count = CW'(rxc); rx_push = psh;
    rx_err = er; rx_err_present = pres; tx_count = CW'(txc); tsr_idle = idle;
    isr_rd = ird; lsr_rd = lrd; thr_wr = twr;
    exp_q.push_back({e_lsr, e_id, e_irq});
    tag_q.push_back(tag);
  endtask

  initial begin
    checks = 0;
    #1;
    if ({lsr, isr_id, irq} !== {8'h60, 4'b0001, 1'b0}) begin
      fails++;
      $display("FAIL R1: in reset lsr=%h id=%b irq=%b expected lsr=60 id=0001 irq=0", lsr, isr_id, irq);
    end
    checks++;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    //   fe  ier    sel  rx   psh err     pres tx idl ird lrd twr  lsr    id       irq
    step(1, 4'h0, 2'd1, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0001, 0, "R1");
    step(1, 4'h0, 2'd1, 40,  0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0001, 0, "R9");
    step(1, 4'h1, 2'd1, 31,  0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0001, 0, "R2");
    step(1, 4'h1, 2'd1, 32,  0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0100, 1, "R2");
    step(1, 4'h1, 2'd1, 31,  0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0001, 0, "R2");
    step(1, 4'h7, 2'd1, 32,  1, 4'h2,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0100, 1, "R11");
    step(1, 4'h7, 2'd1, 32,  0, 4'h0,   1,   0, 1,  0,  0,  0,  8'hE5, 4'b0110, 1, "R7");
    step(1, 4'h7, 2'd1, 32,  0, 4'h0,   1,   0, 1,  0,  1,  0,  8'hE5, 4'b0110, 1, "R7");
    step(1, 4'h7, 2'd1, 32,  0, 4'h0,   1,   0, 1,  0,  0,  0,  8'hE1, 4'b0100, 1, "R8");
    step(1, 4'h7, 2'd1, 32,  0, 4'h0,   0,   0, 1,  0,  1,  0,  8'hE1, 4'b0100, 1, "R8");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0010, 1, "R4");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   0, 1,  1,  0,  0,  8'h60, 4'b0010, 1, "R4");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0001, 0, "R5");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   1, 0,  0,  0,  1,  8'h00, 4'b0001, 0, "R6");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0010, 1, "R5");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   1, 0,  0,  0,  1,  8'h00, 4'b0001, 0, "R5");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   5, 0,  0,  0,  0,  8'h00, 4'b0001, 0, "R6");
    step(1, 4'h7, 2'd1, 32,  0, 4'h0,   0,   0, 1,  1,  0,  0,  8'h61, 4'b0100, 1, "R11");
    step(1, 4'h7, 2'd1, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0010, 1, "R5");
    step(0, 4'h1, 2'd3, 1,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0100, 1, "R10");
    step(0, 4'h3, 2'd3, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h60, 4'b0010, 1, "R10");
    step(1, 4'h1, 2'd3, 127, 0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0001, 0, "R2");
    step(1, 4'h1, 2'd3, 128, 0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0100, 1, "R2");
    step(0, 4'h0, 2'd3, 128, 1, 4'h8,   0,   0, 1,  0,  0,  0,  8'h61, 4'b0001, 0, "R3");
    step(0, 4'h0, 2'd3, 128, 0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h71, 4'b0001, 0, "R8");
    step(1, 4'h0, 2'd0, 0,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h70, 4'b0001, 0, "R3");
    step(1, 4'h1, 2'd0, 1,   0, 4'h0,   0,   0, 1,  0,  0,  0,  8'h71, 4'b0100, 1, "R2");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 10000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule